// File: doc/BRIEF.md
# Hexadecimal Response Frame Encoder

This block turns the answer to a host command into a stream of printable characters for a byte-wide UART transmitter. A response is submitted as a command code, a response kind and a 20-bit byte count. The encoder accepts it only while idle. It then sends an `S` marker and the command code as two hexadecimal characters. Depending on the kind, it also sends the count as five hex characters. For a read, the count is followed by the data words, each sent as eight hex characters.

Read data is pulled one 32-bit word at a time from a valid/ready source. The encoder requests a word only when the previous word has been fully sent. Every output character is offered on a valid/ready pair and is held until the transmitter takes it, so any back-pressure pattern is tolerated.

Top module: `resp_hex_encoder`

## Requirements
- R1: The first character after a request is accepted is 0x53 (`S`), and it is offered in the cycle right after the acceptance edge.
- R2: The command code follows as two hex characters, most significant nibble first. Nibbles 0-9 map to 0x30-0x39 and nibbles 10-15 map to uppercase 0x41-0x46.
- R3: Kind 0 (ping), and the reserved kind 3, produce exactly three characters: the marker and the two command characters.
- R4: Kind 1 (write) appends the count as five hex characters, most significant first, and never requests a data word.
- R5: Kind 2 (read) appends the five count characters and then ceil(count/4) words, each as eight hex characters, most significant first. A count of zero sends no words.
- R6: `word_ready_o` is high only while the encoder waits for its next word. Each requested word is consumed exactly once, on a cycle where `word_valid_i` and `word_ready_o` are both high.
- R7: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` stays unchanged on the next cycle.
- R8: `busy_o` is high from the cycle after acceptance through the handshake of the last character. `req_ready_o` is low during that whole time, and requests presented then are ignored.
- R9: In reset, `tx_valid_o`, `busy_o` and `word_ready_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Response request present |
| req_ready_o | output | 1 | Encoder idle, request will be taken |
| req_kind_i | input | 2 | 0 ping, 1 write, 2 read, 3 treated as ping |
| req_cmd_i | input | 8 | Command code to echo |
| req_count_i | input | 20 | Byte count |
| word_i | input | 32 | Read data word |
| word_valid_i | input | 1 | Read data word present |
| word_ready_o | output | 1 | Encoder takes a word this cycle if valid |
| tx_data_o | output | 8 | Character to transmit |
| tx_valid_o | output | 1 | Character present |
| tx_ready_i | input | 1 | Transmitter accepts the character |
| busy_o | output | 1 | Frame in progress |

## Verification
The marker is due one cycle after the request handshake. Each later character is due one cycle after the previous character's handshake, and a fetched word's first character is due one cycle after the word handshake. A scoreboard therefore compares characters only on handshake cycles, sampled on the falling edge, so stalls from a random `tx_ready_i` pattern cannot shift expected positions. `busy_o` is checked on the first falling edge after acceptance. Completion is checked once `busy_o` drops, when the expected character and word queues must both be empty and `req_ready_o` must be high again.

// File: rtl/resp_enc_pkg.sv
package resp_enc_pkg;
  typedef enum logic [1:0] {
    KIND_PING  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_READ  = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_CMD, ST_CNT, ST_FETCH, ST_DATA
  } state_e;

  localparam logic [7:0] START_CHAR = 8'h53;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/resp_enc_nib2asc.sv
module resp_enc_nib2asc
  import resp_enc_pkg::*;
(
  input  logic [3:0] nib_i,
  output logic [7:0] char_o
);
  always_comb char_o = nib_to_ascii(nib_i);
endmodule

// File: rtl/resp_enc_nibshift.sv
module resp_enc_nibshift #(
  parameter int SH_W = 32,
  parameter int NC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SH_W-1:0] load_val_i,
  input  logic [NC_W-1:0] load_cnt_i,
  input  logic            shift_i,
  output logic [3:0]      nib_o,
  output logic            last_o
);
  logic [SH_W-1:0] sh_q;
  logic [NC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= load_val_i;
      cnt_q <= load_cnt_i;
    end else if (shift_i) begin
      sh_q  <= sh_q << 4;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign nib_o  = sh_q[SH_W-1 -: 4];
  assign last_o = (cnt_q == NC_W'(1));

  // R2
  shift_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/resp_enc_wordcnt.sv
module resp_enc_wordcnt #(
  parameter int CNT_W = 20,
  localparam int WC_W = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             last_o
);
  logic [CNT_W:0]  sum;
  logic [WC_W-1:0] remain_q;

  assign sum = {1'b0, count_i} + (CNT_W+1)'(3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     remain_q <= '0;
    else if (load_i) remain_q <= sum[CNT_W:2];
    else if (dec_i)  remain_q <= remain_q - 1'b1;
  end

  assign zero_o = (remain_q == '0);
  assign last_o = (remain_q == WC_W'(1));

  // R5
  word_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (remain_q != '0));
endmodule

// File: rtl/resp_hex_encoder.sv
module resp_hex_encoder
  import resp_enc_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int CNT_W  = 20,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              busy_o
);
  localparam int SH_W     = WORD_W;
  localparam int CMD_NIB  = CMD_W / 4;
  localparam int CNT_NIB  = CNT_W / 4;
  localparam int WORD_NIB = WORD_W / 4;
  localparam int NC_W     = $clog2(WORD_NIB + 1);

  state_e            state_q, state_d;
  kind_e             kind_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              accept, hs;
  logic              sh_load, sh_shift, sh_last;
  logic [SH_W-1:0]   sh_val;
  logic [NC_W-1:0]   sh_cnt;
  logic [3:0]        nib;
  logic [7:0]        nib_char;
  logic              wc_dec, wc_zero, wc_last;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign busy_o       = (state_q != ST_IDLE);
  assign accept       = req_valid_i && req_ready_o;
  assign tx_valid_o   = (state_q == ST_START) || (state_q == ST_CMD) ||
                        (state_q == ST_CNT)   || (state_q == ST_DATA);
  assign word_ready_o = (state_q == ST_FETCH);
  assign hs           = tx_valid_o && tx_ready_i;
  assign tx_data_o    = (state_q == ST_START) ? START_CHAR : nib_char;

  always_comb begin
    state_d  = state_q;
    sh_load  = 1'b0;
    sh_val   = '0;
    sh_cnt   = '0;
    sh_shift = hs && (state_q != ST_START);
    wc_dec   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_START;
      ST_START: if (hs) begin
        state_d = ST_CMD;
        sh_load = 1'b1;
        sh_val  = {cmd_q, {(SH_W-CMD_W){1'b0}}};
        sh_cnt  = NC_W'(CMD_NIB);
      end
      ST_CMD: if (hs && sh_last) begin
        if (kind_q == KIND_PING || kind_q == KIND_RSVD) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_CNT;
          sh_load = 1'b1;
          sh_val  = {cnt_q, {(SH_W-CNT_W){1'b0}}};
          sh_cnt  = NC_W'(CNT_NIB);
        end
      end
      ST_CNT: if (hs && sh_last)
        state_d = (kind_q != KIND_READ || wc_zero) ? ST_IDLE : ST_FETCH;
      ST_FETCH: if (word_valid_i) begin
        state_d = ST_DATA;
        sh_load = 1'b1;
        sh_val  = word_i;
        sh_cnt  = NC_W'(WORD_NIB);
      end
      ST_DATA: if (hs && sh_last) begin
        wc_dec  = 1'b1;
        state_d = wc_last ? ST_IDLE : ST_FETCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_PING;
      cmd_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_q <= kind_e'(req_kind_i);
        cmd_q  <= req_cmd_i;
        cnt_q  <= req_count_i;
      end
    end
  end

  resp_enc_nibshift #(.SH_W(SH_W), .NC_W(NC_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i     (sh_load),
    .load_val_i (sh_val),
    .load_cnt_i (sh_cnt),
    .shift_i    (sh_shift),
    .nib_o      (nib),
    .last_o     (sh_last)
  );

  resp_enc_nib2asc u_asc (.nib_i(nib), .char_o(nib_char));

  resp_enc_wordcnt #(.CNT_W(CNT_W)) u_wcnt (
    .clk_i, .rst_ni,
    .load_i  (accept),
    .count_i (req_count_i),
    .dec_i   (wc_dec),
    .zero_o  (wc_zero),
    .last_o  (wc_last)
  );

  // R1
  start_char_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (tx_valid_o && tx_data_o == 8'h53));

  // R7
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R6
  word_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> (busy_o && !tx_valid_o));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && !req_ready_o));

  // R2
  char_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_data_o == 8'h53 ||
                    (tx_data_o >= 8'h30 && tx_data_o <= 8'h39) ||
                    (tx_data_o >= 8'h41 && tx_data_o <= 8'h46)));
endmodule

// File: tb/resp_hex_encoder_bench.sv
module resp_hex_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_cmd = '0;
  logic [19:0] req_count = '0;
  logic [31:0] word = '0;
  logic        word_valid = 1'b0, word_ready;
  logic [7:0]  tx_data;
  logic        tx_valid, busy;
  logic        tx_ready = 1'b1;

  int checks = 0, errors = 0;
  int stall_mode = 0;
  bit done = 1'b0;

  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [31:0] word_q[$];

  always #5 clk = ~clk;

  resp_hex_encoder u_resp_hex_encoder (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_cmd_i(req_cmd), .req_count_i(req_count),
    .word_i(word), .word_valid_i(word_valid), .word_ready_o(word_ready),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + 8'(n)) : (8'h37 + 8'(n));
  endfunction

  task automatic push_hex(input logic [31:0] v, input int nibs, input string tag);
    for (int i = nibs - 1; i >= 0; i--) begin
      exp_q.push_back(hexc(4'((v >> (4 * i)) & 32'hF)));
      tag_q.push_back(tag);
    end
  endtask

  // monitor / scoreboard and word source
  initial begin
    bit hold_prev = 1'b0;
    logic [7:0] data_prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy && req_ready) chk(1'b0, "R8 ready while busy", 32'(req_ready), 32'h0);
        if (hold_prev) chk(tx_valid && tx_data == data_prev, "R7 hold", 32'(tx_data), 32'(data_prev));
        hold_prev = tx_valid && !tx_ready;
        data_prev = tx_data;
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0) chk(1'b0, "R3 extra char", 32'(tx_data), 32'h0);
          else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(tx_data == e, t, 32'(tx_data), 32'(e));
          end
        end
        if (word_ready && word_valid) void'(word_q.pop_front());
        if (word_ready && !busy) chk(1'b0, "R6 word_ready idle", 32'h1, 32'h0);
      end
      @(posedge clk);
      #1;
      word_valid = (word_q.size() > 0);
      word = (word_q.size() > 0) ? word_q[0] : 32'h0;
      tx_ready = (stall_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end
  end

  task automatic run_frame(input logic [1:0] kind, input logic [7:0] cmd,
                           input logic [19:0] cnt, input bit junk);
    int t;
    exp_q.push_back(8'h53); tag_q.push_back("R1 start");
    push_hex(32'(cmd), 2, "R2 cmd");
    if (kind == 2'd1) push_hex(32'(cnt), 5, "R4 count");
    if (kind == 2'd2) begin
      push_hex(32'(cnt), 5, "R5 count");
      for (int w = 0; w < (int'(cnt) + 3) / 4; w++) begin
        logic [31:0] d;
        d = $urandom;
        word_q.push_back(d);
        push_hex(d, 8, "R5 word");
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_cmd = cmd; req_count = cnt;
    @(posedge clk);
    #1;
    if (junk) begin
      req_kind = 2'd1; req_cmd = ~cmd; req_count = 20'h12345;
    end else req_valid = 1'b0;
    @(negedge clk);
    #2;
    chk(busy, "R8 busy after accept", 32'(busy), 32'h1);
    if (junk) begin
      repeat (3) @(posedge clk);
      #1 req_valid = 1'b0;
    end
    t = 0;
    while ((busy || exp_q.size() != 0) && t < 3000) begin
      @(negedge clk); #2; t++;
    end
    chk(exp_q.size() == 0, "R3/R4/R5 frame length", 32'(exp_q.size()), 32'h0);
    chk(word_q.size() == 0, "R6 words consumed", 32'(word_q.size()), 32'h0);
    chk(req_ready && !tx_valid && !busy, "R8 idle after frame", {busy, tx_valid, req_ready}, 32'h1);
    exp_q.delete(); tag_q.delete(); word_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk(!tx_valid && !busy && !word_ready && req_ready, "R9 reset",
        {word_ready, busy, tx_valid, req_ready}, 32'h1);
    rst_n = 1'b1;
    run_frame(2'd0, 8'h3C, 20'h0, 1'b0);     // R3 ping
    run_frame(2'd3, 8'hA5, 20'h7, 1'b0);     // R3 reserved kind
    run_frame(2'd1, 8'h02, 20'hABCDE, 1'b0); // R4 write
    run_frame(2'd2, 8'hF0, 20'h0, 1'b0);     // R5 read, zero count
    run_frame(2'd2, 8'h19, 20'h1, 1'b0);     // R5 one word
    run_frame(2'd2, 8'h19, 20'h4, 1'b0);     // R5 exact word
    run_frame(2'd2, 8'h7E, 20'h5, 1'b0);     // R5 rounds up
    stall_mode = 1;
    run_frame(2'd2, 8'hC3, 20'h9, 1'b1);     // R7 R8 stalls and ignored request
    run_frame(2'd1, 8'h4B, 20'h00F10, 1'b0); // R4 R7 with stalls
    run_frame(2'd2, 8'hE8, 20'hC, 1'b0);     // R6 three words with stalls
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule